// File: doc/BRIEF.md
# Watchdog Reset Timer

This block watches over a processor that must prove it is still running by writing to a single 8-bit control register at regular intervals. A fixed prescaler divides the CPU clock. Each time the prescaler completes a period, a 7-bit down-counter held in the low bits of the register decrements by one. The top bit of the register is an activation flag.

While the watchdog is active, the counter's bit 6 falling from one to zero starts a reset cycle. In that cycle an active-low reset output is held low for a fixed number of clock cycles. Bit 6 can fall in two ways: the counter stepping from 40h to 3Fh, or a write. To keep the system alive, software writes a value between C0h and FFh. Bit 7 and bit 6 are then set, and bits 5:0 choose how many prescaler periods remain before expiry, which gives 64 timeout lengths.

Two configuration inputs extend the behaviour. One selects hardware mode, in which the watchdog is active from reset without any software action. The other makes a HALT request from an active watchdog cause a reset.

Top module: `wdt_core`

## Requirements
- R1: After reset is released or after any register write, the counter decrements exactly every PRESCALE clock cycles. A write clears the prescaler, so the next decrement comes PRESCALE cycles after the write edge.
- R2: While the activation flag (bit 7) is clear, the counter passing from 40h to 3Fh produces no reset.
- R3: While the watchdog is active, a fall of counter bit 6 drives the reset output low in the same cycle the register first shows the new count. The fall may come from a decrement or from a write. A write whose bit 6 leaves bit 6 at zero produces no reset.
- R4: Each reset cycle keeps the reset output low for exactly PULSE_CYCLES cycles. A trigger that arrives while the output is already low neither extends nor restarts the pulse.
- R5: Once set, the activation flag stays set until a system reset. A write with bit 7 low loads the counter and leaves the flag at one.
- R6: A register write loads bits 6:0 of the write data into the counter in the cycle after the write edge.
- R7: In hardware mode the register reads FFh after reset, and the watchdog expires without any write once the counter falls from 40h to 3Fh.
- R8: When the halt-reset option is set and the watchdog is active, a HALT request starts a reset cycle. When the option is clear or the watchdog is inactive, a HALT request has no effect on the reset output.
- R9: A read returns the activation flag in bit 7 and the current counter in bits 6:0. After reset in software mode the read value is 7Fh.
- R10: The counter wraps from 00h to 7Fh on the next decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous system reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value: flag and counter |
| halt_req_i | input | 1 | HALT request from the core |
| hw_mode_i | input | 1 | Hardware watchdog option: active from reset |
| halt_rst_en_i | input | 1 | Option: a HALT request while active causes a reset |
| wdt_rst_n_o | output | 1 | Reset output, active low |

## Verification
The bench builds the block with PRESCALE set to 8 and PULSE_CYCLES set to 3. With these values a full pass of the counter takes about a thousand cycles, so the tests reach several cases in a short run: the complete 7Fh-to-00h wrap, expiry both with the flag set and with it clear, and a restart written one cycle before a decrement is due. Because the pulse is shorter than a prescaler period, a HALT request held through the whole pulse can be watched: the output returns high for exactly one cycle and then goes low again. A second reset in hardware mode covers expiry that needs no write at all.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W = 7;
    localparam int REG_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_RESET = '1;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] count;
    } wdt_ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(wdt_ctrl_t c);
        return {c.active, c.count};
    endfunction

    function automatic logic msb_fell(logic [CNT_W-1:0] prev, logic [CNT_W-1:0] next);
        return prev[CNT_W-1] && !next[CNT_W-1];
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRESCALE = 12288
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    assign tick_o = !restart_i && (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    generate
        if (PRESCALE > 1) begin : g_spacing
            // R1
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_mode_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             tick_i,
    output wdt_ctrl_t        ctrl_o,
    output logic             expire_o
);
    wdt_ctrl_t ctrl_q, ctrl_d;

    always_comb begin
        ctrl_d        = ctrl_q;
        ctrl_d.active = ctrl_q.active | hw_mode_i | (wr_en_i & wr_data_i[REG_W-1]);
        if (wr_en_i) begin
            ctrl_d.count = wr_data_i[CNT_W-1:0];
        end else if (tick_i) begin
            ctrl_d.count = ctrl_q.count - 1'b1;
        end
    end

    assign expire_o = ctrl_d.active && msb_fell(ctrl_q.count, ctrl_d.count);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.active <= hw_mode_i;
            ctrl_q.count  <= CNT_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

    // R5
    active_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.active |=> ctrl_q.active);

    // R1
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wr_en_i) |=> $stable(ctrl_q.count));

    // R6
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> ctrl_q.count == $past(wr_data_i[CNT_W-1:0]));

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger_i,
    output logic rst_n_o
);
    localparam int LW = $clog2(PULSE_CYCLES + 1);
    localparam logic [LW-1:0] LOAD = LW'(PULSE_CYCLES);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else if (trigger_i) begin
            left_q <= LOAD;
        end
    end

    assign rst_n_o = (left_q == '0);

    // R4
    pulse_no_extend_chk: assert property (@(posedge clk) disable iff (rst)
        (left_q != '0) |=> left_q == $past(left_q) - 1'b1);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int PRESCALE     = 12288,
    parameter int PULSE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             halt_req_i,
    input  logic             hw_mode_i,
    input  logic             halt_rst_en_i,
    output logic             wdt_rst_n_o
);
    logic      tick;
    logic      expire;
    logic      halt_kill;
    wdt_ctrl_t ctrl;

    wdt_prescaler #(.PRESCALE(PRESCALE)) u_div (
        .clk       (clk),
        .rst       (rst),
        .restart_i (wr_en_i),
        .tick_o    (tick)
    );

    wdt_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .hw_mode_i (hw_mode_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .tick_i    (tick),
        .ctrl_o    (ctrl),
        .expire_o  (expire)
    );

    assign halt_kill = halt_rst_en_i && ctrl.active && halt_req_i;

    wdt_rst_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .trigger_i (expire || halt_kill),
        .rst_n_o   (wdt_rst_n_o)
    );

    assign rd_data_o = pack_ctrl(ctrl);

    // R2
    no_reset_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_rst_n_o) |-> rd_data_o[REG_W-1]);

    // R3
    expire_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && wdt_rst_n_o) |=> !wdt_rst_n_o);

    // R8
    halt_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_kill && wdt_rst_n_o) |=> !wdt_rst_n_o);

endmodule

// File: tb/wdt_core_test.sv
module wdt_core_test;
    localparam int P   = 8;
    localparam int PUL = 3;

    logic       clk = 0;
    logic       rst = 1;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       halt = 0;
    logic       hw = 0;
    logic       hopt = 0;
    logic       rst_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wdt_core #(.PRESCALE(P), .PULSE_CYCLES(PUL)) uut (
        .clk           (clk),
        .rst           (rst),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .halt_req_i    (halt),
        .hw_mode_i     (hw),
        .halt_rst_en_i (hopt),
        .wdt_rst_n_o   (rst_n)
    );

    // behavioural reference model
    int m_act = 0, m_cnt = 0, m_pre = 0, m_pls = 0;
    int n_act = 0, n_cnt = 0;
    bit m_tick = 0, m_trig = 0, m_valid = 0;

    always @(posedge clk) begin
        m_valid = 1;
        if (rst) begin
            m_act = hw ? 1 : 0;
            m_cnt = 127;
            m_pre = 0;
            m_pls = 0;
        end else begin
            m_tick = !wr_en && (m_pre == P - 1);
            m_pre  = wr_en ? 0 : ((m_pre == P - 1) ? 0 : m_pre + 1);
            n_act  = (m_act != 0 || hw || (wr_en && wr_data[7])) ? 1 : 0;
            n_cnt  = wr_en ? int'(wr_data) % 128 : (m_tick ? (m_cnt + 127) % 128 : m_cnt);
            m_trig = (n_act != 0 && m_cnt >= 64 && n_cnt < 64) ||
                     (hopt && m_act != 0 && halt);
            if (m_pls > 0) m_pls = m_pls - 1;
            else if (m_trig) m_pls = PUL;
            m_act = n_act;
            m_cnt = n_cnt;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid) begin
            chk(rd_data == 8'((m_act << 7) | m_cnt), "R9 model read", rd_data, (m_act << 7) | m_cnt);
            chk(rst_n == (m_pls == 0), "R4 model reset output", rst_n, m_pls == 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en   = 1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        step(3);
        rst = 0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog timeout");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk(rd_data == 8'h7F, "R9 reset read", rd_data, 8'h7F);
        chk(rst_n == 1, "R9 reset output high", rst_n, 1);

        // inactive expiry
        step(64 * P);
        chk(rd_data == 8'h3F, "R2 count at 3F", rd_data, 8'h3F);
        chk(rst_n == 1, "R2 no reset while inactive", rst_n, 1);
        step(63 * P);
        chk(rd_data == 8'h00, "R10 count at 00", rd_data, 8'h00);
        step(P);
        chk(rd_data == 8'h7F, "R10 wrap to 7F", rd_data, 8'h7F);

        // active countdown
        wr(8'hC3);
        chk(rd_data == 8'hC3, "R6 write loads", rd_data, 8'hC3);
        step(P);
        chk(rd_data == 8'hC2, "R1 first decrement", rd_data, 8'hC2);
        step(P - 1);
        chk(rd_data == 8'hC2, "R1 no early decrement", rd_data, 8'hC2);
        step(1);
        chk(rd_data == 8'hC1, "R1 second decrement", rd_data, 8'hC1);
        step(P);
        step(P - 1);
        chk(rd_data == 8'hC0 && rst_n == 1, "R3 at 40 no reset yet", {rst_n, rd_data}, {1'b1, 8'hC0});
        step(1);
        chk(rd_data == 8'hBF, "R3 count 3F", rd_data, 8'hBF);
        chk(rst_n == 0, "R3 expiry reset", rst_n, 0);
        step(PUL - 1);
        chk(rst_n == 0, "R4 pulse still low", rst_n, 0);
        step(1);
        chk(rst_n == 1, "R4 pulse ends", rst_n, 1);

        // sticky flag, write with bit6 already low
        wr(8'h05);
        chk(rd_data == 8'h85, "R5 flag sticky", rd_data, 8'h85);
        step(1);
        chk(rst_n == 1, "R3 no fall no reset", rst_n, 1);

        // restart of prescaler
        wr(8'hFF);
        step(P - 2);
        wr(8'hFF);
        step(P - 1);
        chk(rd_data == 8'hFF, "R1 restart delays decrement", rd_data, 8'hFF);
        step(1);
        chk(rd_data == 8'hFE, "R1 decrement after restart", rd_data, 8'hFE);

        // immediate reset by write, halt held during pulse
        wr(8'h3F);
        chk(rst_n == 0, "R3 write clears bit6 -> reset", rst_n, 0);
        chk(rd_data == 8'hBF, "R5 flag kept on write", rd_data, 8'hBF);
        hopt = 1;
        halt = 1;
        step(PUL - 1);
        chk(rst_n == 0, "R4 pulse held", rst_n, 0);
        step(1);
        chk(rst_n == 1, "R4 no extension during pulse", rst_n, 1);
        step(1);
        chk(rst_n == 0, "R8 halt reset", rst_n, 0);
        halt = 0;
        step(PUL);
        chk(rst_n == 1, "R8 pulse done", rst_n, 1);
        hopt = 0;
        halt = 1;
        step(3);
        chk(rst_n == 1, "R8 halt ignored without option", rst_n, 1);
        halt = 0;

        // halt with option but inactive
        do_reset();
        hopt = 1;
        halt = 1;
        step(4);
        chk(rst_n == 1, "R8 halt ignored while inactive", rst_n, 1);
        halt = 0;
        hopt = 0;

        // hardware mode
        hw = 1;
        do_reset();
        chk(rd_data == 8'hFF, "R7 hardware mode reset read", rd_data, 8'hFF);
        step(64 * P);
        chk(rd_data == 8'hBF, "R7 count 3F", rd_data, 8'hBF);
        chk(rst_n == 0, "R7 hardware mode expiry", rst_n, 0);
        step(PUL);
        hw = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule